// File: doc/BRIEF.md
# Memory Channel Supervisor Registers

This block is the register-side supervisor for a group of up to four external memory channels. A 64-bit register bus with single-cycle access reads a status word and a control word. The status word collects each channel's initialization-complete and calibration-failure flags. It also shows a per-channel busy flag that tracks an outstanding clear operation.

Software starts a clear by writing a one into a trigger bit of the control word. The block sends a one-cycle clear pulse to that channel and raises the channel's busy flag. The flag drops once the channel reports that the clear has completed. The trigger field cannot be read back. Reading it returns a presence map, fixed at build time, that tells software which channels are fitted. All other control bits are plain storage.

Top module: `memif_supervisor`

## Requirements
- R1: While `rst_n` is low and after its release, no busy flag is set and no clear pulse is driven. The control word reads as the presence map in bits [3:0] with zeros above it.
- R2: A read at byte address 0x08 returns the status word. Bits [3:0] hold the init-done inputs, bits [11:8] hold the cal-fail inputs and bits [19:16] hold the busy flags. Channel n uses the field base plus n, and only channels marked present are shown. Every other status bit reads 0.
- R3: Bits [3:0] of a read at byte address 0x10 always return the `PRESENT_MAP` parameter (default 4'b1011, so channel 2 is absent), whatever was last written there.
- R4: Control bits [63:4] keep the value last written at address 0x10 and read it back.
- R5: Writing 1 to control bit n of a present, idle channel drives `ch_clear_req[n]` high for exactly one cycle, the cycle after the write edge. The busy flag of that channel is set in the same cycle.
- R6: A busy flag stays set until `ch_clear_done[n]` is sampled high on a clock edge. It reads 0 from the next cycle on.
- R7: A trigger bit for a channel that is not in the presence map produces no pulse and no busy flag.
- R8: A trigger for a channel whose busy flag is set produces no new pulse and leaves the flag set.
- R9: Writes to the status address or to unmapped addresses change nothing. Reads of unmapped addresses return 0.
- R10: Several trigger bits in one write act on each present channel independently, and each busy flag is cleared only by its own channel's done input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| reg_addr | input | ADDR_W (8) | Byte address of the register access |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wr_data | input | 64 | Write data |
| reg_rd_data | output | 64 | Read data for `reg_addr`, combinational |
| ch_init_done | input | 4 | Per-channel initialization-complete flags |
| ch_cal_fail | input | 4 | Per-channel calibration-failure flags |
| ch_clear_req | output | 4 | Per-channel one-cycle clear pulses |
| ch_clear_done | input | 4 | Per-channel clear-completion indications |

## Verification
The bench targets the trigger field in three ways. It reads the field back after writes, where a design that stored the field would return the written bits instead of the presence map. It aims a trigger at the absent channel, where a design without presence gating would pulse it and leave a busy flag set that never clears. It re-triggers a busy channel, where a design that restarts would pulse a second time. Multi-channel writes with done arriving on one channel at a time catch busy flags that are shared or cleared by another channel's done. Writes to the status address and to an unmapped address check that neither storage nor pulses are disturbed by stray decodes.

// File: rtl/memif_pkg.sv
package memif_pkg;
  localparam int MAX_CH    = 4;
  localparam int DATA_W    = 64;
  localparam int STAT_OFS  = 8;
  localparam int CTRL_OFS  = 16;
  localparam int INIT_BASE = 0;
  localparam int FAIL_BASE = 8;
  localparam int BUSY_BASE = 16;
endpackage

// File: rtl/memif_chan_tracker.sv
module memif_chan_tracker #(
  parameter bit PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic done,
  output logic busy,
  output logic clear_pulse
);
  generate
    if (PRESENT) begin : g_live
      logic busy_q, busy_d;
      logic pulse_q, pulse_d;
      logic start;

      always_comb begin
        start   = launch & ~busy_q;
        pulse_d = start;
        if (busy_q) busy_d = ~done;
        else        busy_d = start;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busy_q  <= 1'b0;
          pulse_q <= 1'b0;
        end else begin
          busy_q  <= busy_d;
          pulse_q <= pulse_d;
        end
      end

      assign busy        = busy_q;
      assign clear_pulse = pulse_q;
    end else begin : g_absent
      assign busy        = 1'b0;
      assign clear_pulse = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/memif_ctrl_store.sv
module memif_ctrl_store #(
  parameter int DATA_W = 64,
  parameter int TRIG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] stored
);
  localparam int KEEP_W = DATA_W - TRIG_W;

  logic [KEEP_W-1:0] keep_q, keep_d;

  always_comb begin
    keep_d = keep_q;
    if (wr_en) keep_d = wr_data[DATA_W-1:TRIG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) keep_q <= '0;
    else        keep_q <= keep_d;
  end

  assign stored = {keep_q, {TRIG_W{1'b0}}};
endmodule

// File: rtl/memif_supervisor.sv
module memif_supervisor
  import memif_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [MAX_CH-1:0] PRESENT_MAP = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic [MAX_CH-1:0] ch_init_done,
  input  logic [MAX_CH-1:0] ch_cal_fail,
  output logic [MAX_CH-1:0] ch_clear_req,
  input  logic [MAX_CH-1:0] ch_clear_done
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);

  logic              hit_stat, hit_ctrl, wr_ctrl;
  logic [MAX_CH-1:0] busy_vec;
  logic [DATA_W-1:0] ctrl_word, stat_word;

  always_comb begin
    hit_stat = (reg_addr == STAT_ADDR);
    hit_ctrl = (reg_addr == CTRL_ADDR);
    wr_ctrl  = reg_wr_en & hit_ctrl;
  end

  memif_ctrl_store #(
    .DATA_W (DATA_W),
    .TRIG_W (MAX_CH)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ctrl),
    .wr_data (reg_wr_data),
    .stored  (ctrl_word)
  );

  for (genvar n = 0; n < MAX_CH; n++) begin : g_ch
    memif_chan_tracker #(
      .PRESENT (PRESENT_MAP[n])
    ) u_trk (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (wr_ctrl & reg_wr_data[n]),
      .done        (ch_clear_done[n]),
      .busy        (busy_vec[n]),
      .clear_pulse (ch_clear_req[n])
    );
  end

  always_comb begin
    stat_word = '0;
    for (int n = 0; n < MAX_CH; n++) begin
      stat_word[INIT_BASE+n] = ch_init_done[n] & PRESENT_MAP[n];
      stat_word[FAIL_BASE+n] = ch_cal_fail[n]  & PRESENT_MAP[n];
      stat_word[BUSY_BASE+n] = busy_vec[n];
    end
  end

  always_comb begin
    if (hit_stat)      reg_rd_data = stat_word;
    else if (hit_ctrl) reg_rd_data = ctrl_word | DATA_W'(PRESENT_MAP);
    else               reg_rd_data = '0;
  end
endmodule

// File: rtl/memif_supervisor_chk.sv
module memif_supervisor_chk
  import memif_pkg::*;
#(
  parameter logic [MAX_CH-1:0] PRESENT_MAP = 4'b1011
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MAX_CH-1:0] ch_clear_req,
  input logic [MAX_CH-1:0] ch_clear_done,
  input logic [MAX_CH-1:0] busy_vec
);
  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_clear_req & $past(ch_clear_req)) == '0);

  // R5
  pulse_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_clear_req & ~busy_vec) == '0);

  // R7
  absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_clear_req | busy_vec) & ~PRESENT_MAP) == '0);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_vec) & ~busy_vec & ~$past(ch_clear_done)) == '0);

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_vec & ~$past(busy_vec)) == ch_clear_req);
endmodule

bind memif_supervisor memif_supervisor_chk #(
  .PRESENT_MAP (PRESENT_MAP)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ch_clear_req  (ch_clear_req),
  .ch_clear_done (ch_clear_done),
  .busy_vec      (busy_vec)
);

// File: tb/tb_memif_supervisor.sv
module tb_memif_supervisor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [63:0] reg_wr_data = '0;
  logic [63:0] reg_rd_data;
  logic [3:0]  ch_init_done = '0;
  logic [3:0]  ch_cal_fail = '0;
  logic [3:0]  ch_clear_req;
  logic [3:0]  ch_clear_done = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  memif_supervisor dut (
    .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr_en (reg_wr_en),
    .reg_wr_data (reg_wr_data), .reg_rd_data (reg_rd_data),
    .ch_init_done (ch_init_done), .ch_cal_fail (ch_cal_fail),
    .ch_clear_req (ch_clear_req), .ch_clear_done (ch_clear_done)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rd_data;
  endtask

  task automatic pulse_done(logic [3:0] m);
    @(negedge clk);
    ch_clear_done = m;
    @(negedge clk);
    ch_clear_done = '0;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(8'h10, v); chk("R1 ctrl in reset", v, 64'hB);
    rd(8'h08, v); chk("R1 status in reset", v, 64'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h10, v); chk("R1 ctrl after reset", v, 64'hB);
    chk("R1 no pulse", 64'(ch_clear_req), 64'h0);
  endtask

  task automatic t_status;
    logic [63:0] v;
    ch_init_done = 4'b1111; ch_cal_fail = 4'b0101;
    rd(8'h08, v); chk("R2 status fields", v, 64'h10B);
    ch_init_done = 4'b0010; ch_cal_fail = 4'b1000;
    rd(8'h08, v); chk("R2 status fields b", v, 64'h802);
    ch_init_done = '0; ch_cal_fail = '0;
  endtask

  task automatic t_ctrl_rw;
    logic [63:0] v;
    wr(8'h10, 64'hA5A5_0000_1234_5670);
    rd(8'h10, v); chk("R3 R4 ctrl readback", v, 64'hA5A5_0000_1234_567B);
    wr(8'h10, 64'h0);
    rd(8'h10, v); chk("R4 ctrl cleared", v, 64'hB);
  endtask

  task automatic t_clear;
    logic [63:0] v;
    wr(8'h10, 64'h1);
    chk("R5 pulse ch0", 64'(ch_clear_req), 64'h1);
    rd(8'h08, v); chk("R5 busy ch0", v, 64'h10000);
    rd(8'h10, v); chk("R3 trigger not stored", v, 64'hB);
    @(negedge clk);
    chk("R5 pulse one cycle", 64'(ch_clear_req), 64'h0);
    repeat (3) @(negedge clk);
    rd(8'h08, v); chk("R6 busy held", v, 64'h10000);
    pulse_done(4'b0001);
    rd(8'h08, v); chk("R6 busy cleared", v, 64'h0);
  endtask

  task automatic t_absent;
    logic [63:0] v;
    wr(8'h10, 64'h4);
    chk("R7 no pulse absent", 64'(ch_clear_req), 64'h0);
    rd(8'h08, v); chk("R7 no busy absent", v, 64'h0);
  endtask

  task automatic t_busy_ignore;
    logic [63:0] v;
    wr(8'h10, 64'h2);
    chk("R5 pulse ch1", 64'(ch_clear_req), 64'h2);
    wr(8'h10, 64'h2);
    chk("R8 no repulse", 64'(ch_clear_req), 64'h0);
    rd(8'h08, v); chk("R8 still busy", v, 64'h20000);
    pulse_done(4'b0010);
    rd(8'h08, v); chk("R8 R6 cleared", v, 64'h0);
  endtask

  task automatic t_multi;
    logic [63:0] v;
    wr(8'h10, 64'hF);
    chk("R10 multi pulse", 64'(ch_clear_req), 64'hB);
    rd(8'h08, v); chk("R10 multi busy", v, 64'hB0000);
    pulse_done(4'b1000);
    rd(8'h08, v); chk("R10 ch3 only cleared", v, 64'h30000);
    pulse_done(4'b0011);
    rd(8'h08, v); chk("R10 all cleared", v, 64'h0);
  endtask

  task automatic t_stray;
    logic [63:0] v;
    wr(8'h10, 64'hCAFE_0000_0000_0000);
    wr(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R9 status write no pulse", 64'(ch_clear_req), 64'h0);
    rd(8'h08, v); chk("R9 status unchanged", v, 64'h0);
    wr(8'h18, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R9 stray write no pulse", 64'(ch_clear_req), 64'h0);
    rd(8'h10, v); chk("R9 ctrl unchanged", v, 64'hCAFE_0000_0000_000B);
    rd(8'h18, v); chk("R9 unmapped read", v, 64'h0);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_status();
    t_ctrl_rw();
    t_clear();
    t_absent();
    t_busy_ignore();
    t_multi();
    t_stray();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule